// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 32-bit physical address by reading a two-level page table out of memory. A translate request carries the virtual address and the physical address of the current page directory. The walker reads the directory entry, follows it to a second-level table, reads that entry, and attaches the untranslated page offset to the frame it found.

The virtual address splits into three fields. Bits 31:22 index the directory, bits 21:12 index the second-level table, and bits 11:0 are the offset within a 4 KiB page. Every entry is one 32-bit word. Bit 0 of an entry is its valid flag, and bits 31:12 hold a 4 KiB-aligned physical base.

The walker has a single-outstanding memory read port. It holds a read strobe for one cycle and then waits for a response-valid pulse that carries the data. It works on one request at a time and reports each result with a one-cycle done pulse. That pulse carries either the physical address or a fault flag, together with the virtual address that was translated.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `mem_rd_o` and `done_o` are 0.
- R2: The first read of a walk uses the address {base[31:12], va[31:22], 2'b00}. The low 12 bits of the base input are ignored.
- R3: Each read strobe lasts exactly one cycle. No new strobe is issued until the response to the previous read has arrived.
- R4: If the directory entry has bit 0 clear, the walk ends with `done_fault_o`=1 after exactly one memory read, and `done_vaddr_o` equals the requested address.
- R5: The second read uses the address {pde[31:12], va[21:12], 2'b00}, where pde is the directory entry. Bits 11:1 of that entry are ignored.
- R6: If the second-level entry has bit 0 clear, the walk ends with `done_fault_o`=1 after exactly two memory reads.
- R7: A successful walk reports `done_fault_o`=0 and `done_paddr_o` = {pte[31:12], va[11:0]}. Bits 11:1 of the second-level entry are ignored.
- R8: `done_o` lasts exactly one cycle. `req_ready_o` is 0 from the cycle after a request is accepted until the cycle after `done_o`, when it returns to 1.
- R9: The base input is captured when a request is accepted. Changing it later in the walk does not alter the addresses read or the result.
- R10: A response-valid pulse that arrives while no read is outstanding starts nothing: no read and no done pulse follow, and `req_ready_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translate request |
| req_ready_o | output | 1 | Walker is idle and accepts a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| dir_base_i | input | 32 | Physical address of the page directory |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_addr_o | output | 32 | Read address, valid while `mem_rd_o` is 1 |
| mem_rvalid_i | input | 1 | Read response pulse |
| mem_rdata_i | input | 32 | Read response data |
| done_o | output | 1 | One-cycle result pulse |
| done_fault_o | output | 1 | The walk ended in a page fault |
| done_paddr_o | output | 32 | Translated physical address |
| done_vaddr_o | output | 32 | Virtual address of the completed walk |

## Verification
The bench sweeps directory and table indices that include both ends, 0 and 1023. It places invalid entries at both levels, and it fills bits 11:1 of every entry with a non-zero pattern. A walker that drops the valid check on either level would issue a stray second read or report a translation where a fault belongs. A walker that leaks entry flag bits into an address would produce wrong read or result addresses.

The bench varies the memory latency and uses a directory base with non-zero low bits. It also changes the base input in the middle of a walk. A design that strobes a read before the previous response, fails to ignore the base low bits, or reads the base live rather than capturing it would read the wrong entries. Stray response pulses sent while the walker is idle catch an FSM that reacts to responses it never asked for.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_PTE,
    ST_WT_PTE,
    ST_DONE
  } walk_state_e;

endpackage

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
  parameter int PA_W  = 32,
  parameter int PG_LG = 12
) (
  input  logic [PA_W-1:0]       entry_i,
  output logic                  valid_o,
  output logic [PA_W-PG_LG-1:0] frame_o
);
  assign valid_o = entry_i[0];
  assign frame_o = entry_i[PA_W-1:PG_LG];
endmodule

// File: rtl/pt_addr_join.sv
module pt_addr_join #(
  parameter int PA_W   = 32,
  parameter int PG_LG  = 12,
  parameter int IDX_W  = 10,
  parameter int ENT_LG = 2
) (
  input  logic [PA_W-PG_LG-1:0] frame_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [PA_W-1:0]       addr_o
);
  localparam int PAD_W = PA_W - IDX_W;

  logic [PA_W-1:0] idx_ext;

  assign idx_ext = {{PAD_W{1'b0}}, idx_i};
  assign addr_o  = {frame_i, {PG_LG{1'b0}}} | (idx_ext << ENT_LG);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int IDX_W  = 10,
  parameter int PG_LG  = 12,
  parameter int ENT_LG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic [PA_W-1:0] dir_base_i,
  output logic            mem_rd_o,
  output logic [PA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [PA_W-1:0] mem_rdata_i,
  output logic            done_o,
  output logic            done_fault_o,
  output logic [PA_W-1:0] done_paddr_o,
  output logic [VA_W-1:0] done_vaddr_o
);
  localparam int FRM_W  = PA_W - PG_LG;
  localparam int TBL_LO = PG_LG;
  localparam int DIR_LO = PG_LG + IDX_W;

  walk_state_e state_q, state_d;
  logic [VA_W-1:0]  vaddr_q;
  logic [FRM_W-1:0] dir_frm_q, pt_frm_q;
  logic [PA_W-1:0]  paddr_q;
  logic             fault_q;

  logic             ent_valid;
  logic [FRM_W-1:0] ent_frame;
  logic [PA_W-1:0]  pde_addr, pte_addr;
  logic [IDX_W-1:0] dir_idx, tbl_idx;

  assign dir_idx = vaddr_q[DIR_LO +: IDX_W];
  assign tbl_idx = vaddr_q[TBL_LO +: IDX_W];

  pt_entry_decode #(.PA_W(PA_W), .PG_LG(PG_LG)) u_dec (
    .entry_i (mem_rdata_i),
    .valid_o (ent_valid),
    .frame_o (ent_frame)
  );

  pt_addr_join #(.PA_W(PA_W), .PG_LG(PG_LG), .IDX_W(IDX_W), .ENT_LG(ENT_LG)) u_pde_addr (
    .frame_i (dir_frm_q),
    .idx_i   (dir_idx),
    .addr_o  (pde_addr)
  );

  pt_addr_join #(.PA_W(PA_W), .PG_LG(PG_LG), .IDX_W(IDX_W), .ENT_LG(ENT_LG)) u_pte_addr (
    .frame_i (pt_frm_q),
    .idx_i   (tbl_idx),
    .addr_o  (pte_addr)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_RD_DIR;
      ST_RD_DIR: state_d = ST_WT_DIR;
      ST_WT_DIR: if (mem_rvalid_i) state_d = ent_valid ? ST_RD_PTE : ST_DONE;
      ST_RD_PTE: state_d = ST_WT_PTE;
      ST_WT_PTE: if (mem_rvalid_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      vaddr_q   <= '0;
      dir_frm_q <= '0;
      pt_frm_q  <= '0;
      paddr_q   <= '0;
      fault_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q   <= req_vaddr_i;
          dir_frm_q <= dir_base_i[PA_W-1:PG_LG];  // base captured at accept
          fault_q   <= 1'b0;
          paddr_q   <= '0;
        end
        ST_WT_DIR: if (mem_rvalid_i) begin
          pt_frm_q <= ent_frame;
          fault_q  <= !ent_valid;
        end
        ST_WT_PTE: if (mem_rvalid_i) begin
          fault_q <= !ent_valid;
          paddr_q <= ent_valid ? {ent_frame, vaddr_q[PG_LG-1:0]} : '0;
        end
        default: ;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_rd_o     = (state_q == ST_RD_DIR) || (state_q == ST_RD_PTE);
  assign mem_addr_o   = (state_q == ST_RD_PTE) ? pte_addr : pde_addr;
  assign done_o       = (state_q == ST_DONE);
  assign done_fault_o = fault_q;
  assign done_paddr_o = paddr_q;
  assign done_vaddr_o = vaddr_q;

  p_strobe_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_no_strobe_in_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WT_DIR || state_q == ST_WT_PTE) && !mem_rvalid_i) |=> !mem_rd_o);

  p_dir_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WT_DIR && mem_rvalid_i && !mem_rdata_i[0]) |=> (done_o && done_fault_o));

  p_offset_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_fault_o) |-> (done_paddr_o[PG_LG-1:0] == done_vaddr_o[PG_LG-1:0]));

  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  p_stray_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i) |=> (req_ready_o && !mem_rd_o));

endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] dir_base = '0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic        done_fault;
  logic [31:0] done_paddr;
  logic [31:0] done_vaddr;

  int n_checks = 0;
  int n_fail = 0;

  int          lat = 1;
  int          resp_left = 0;
  logic        pending = 1'b0;
  logic        stray_req = 1'b0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [4];
  int          strobe_viol = 0;

  always #5 clk = ~clk;

  pt_walker dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_vaddr_i  (req_vaddr),
    .dir_base_i   (dir_base),
    .mem_rd_o     (mem_rd),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .done_o       (done),
    .done_fault_o (done_fault),
    .done_paddr_o (done_paddr),
    .done_vaddr_o (done_vaddr)
  );

  // Directory words live below 0x1000_0000, table words above it.
  // Bits 11:1 of every entry carry junk that must be ignored.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    int i, k;
    i = int'(a[11:2]);
    if (a[31:28] == 4'h0) begin
      w = 32'h1000_0000 | (32'(a[17:16]) << 22) | (32'(i) << 12) | 32'h0000_0F5E;
      w[0] = ((i + int'(a[17:16])) % 3) != 0;
    end else begin
      k = int'(a[27:12]);
      w = 32'h8000_0000 + ((32'(k) * 32'd1031 + 32'(i) * 32'd7) << 12);
      w[11:0] = 12'hAAE;
      w[0] = ((k + i) % 5) != 0;
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory responder: one outstanding read, latency lat cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (resp_left > 0) begin
        resp_left--;
        if (resp_left == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(rd_addr[(rd_cnt - 1) & 3]);
        end
      end else if (mem_rvalid) begin
        mem_rvalid = 1'b0;
        pending    = 1'b0;
      end else if (stray_req) begin
        mem_rvalid = 1'b1;
        mem_rdata  = 32'h1234_5001;
        stray_req  = 1'b0;
      end
      if (mem_rd && rst_n) begin
        if (pending) strobe_viol++;
        rd_addr[rd_cnt & 3] = mem_addr;
        rd_cnt++;
        pending   = 1'b1;
        resp_left = lat;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit chg);
    logic [31:0] pde_a, pde, pte_a, pte, exp_pa;
    logic        exp_fault;
    int          exp_reads, cyc;
    bit          rdy_bad;
    int          viol0;
    pde_a = {base[31:12], va[31:22], 2'b00};
    pde   = mem_word(pde_a);
    pte_a = {pde[31:12], va[21:12], 2'b00};
    pte   = mem_word(pte_a);
    if (!pde[0]) begin
      exp_fault = 1'b1; exp_reads = 1; exp_pa = '0;
    end else if (!pte[0]) begin
      exp_fault = 1'b1; exp_reads = 2; exp_pa = '0;
    end else begin
      exp_fault = 1'b0; exp_reads = 2; exp_pa = {pte[31:12], va[11:0]};
    end
    @(negedge clk);
    rd_cnt = 0;
    viol0 = strobe_viol;
    req_valid = 1'b1; req_vaddr = va; dir_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    if (chg) dir_base = base ^ 32'h0003_F000;  // R9: change base mid-walk
    rdy_bad = 0; cyc = 0;
    while (!done && cyc < 100) begin
      if (req_ready) rdy_bad = 1;
      @(negedge clk);
      cyc++;
    end
    check("R8 busy ready low", {31'd0, rdy_bad}, 32'd0);
    check("R8 done seen", {31'd0, done}, 32'd1);
    check("R3 strobe order", 32'(strobe_viol - viol0), 32'd0);
    check(chg ? "R9 dir read addr" : "R2 dir read addr", rd_addr[0], pde_a);
    if (exp_reads == 1) check("R4 read count", 32'(rd_cnt), 32'd1);
    else begin
      check("R6 read count", 32'(rd_cnt), 32'd2);
      check("R5 pte read addr", rd_addr[1], pte_a);
    end
    check(exp_reads == 1 ? "R4 fault flag" : "R6 fault flag", {31'd0, done_fault}, {31'd0, exp_fault});
    check("R4 vaddr", done_vaddr, va);
    if (!exp_fault) check("R7 paddr", done_paddr, exp_pa);
    @(negedge clk);
    check("R8 done pulse width", {31'd0, done}, 32'd0);
    check("R8 ready after done", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    check("R1 mem_rd", {31'd0, mem_rd}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: stray response while idle
    stray_req = 1'b1;
    rd_cnt = 0;
    repeat (4) begin
      @(negedge clk);
      check("R10 idle ready", {31'd0, req_ready}, 32'd1);
      check("R10 no done", {31'd0, done}, 32'd0);
    end
    check("R10 no read", 32'(rd_cnt), 32'd0);

    for (int b = 0; b < 2; b++) begin
      for (int di = 0; di < 14; di++) begin
        for (int ti = 0; ti < 4; ti++) begin
          logic [31:0] base, va;
          logic [9:0]  d_idx, t_idx;
          d_idx = (di == 13) ? 10'd1023 : 10'(di);
          case (ti)
            0: t_idx = 10'd0;
            1: t_idx = 10'd1;
            2: t_idx = 10'd513;
            default: t_idx = 10'd1023;
          endcase
          base = (b == 0) ? 32'h0001_07FC : 32'h0002_0000;
          va   = {d_idx, t_idx, 12'((di * 37 + ti * 1011 + b * 5) & 12'hFFF)};
          lat  = 1 + (n % 3);
          walk(va, base, (n % 4) == 3);
          n++;
          if ((n % 9) == 0) begin
            stray_req = 1'b1;
            rd_cnt = 0;
            repeat (3) @(negedge clk);
            check("R10 stray idle read", 32'(rd_cnt), 32'd0);
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule